// File: doc/BRIEF.md
# Exception Priority Masking Filter

This block decides, every cycle, whether one pending exception may be taken given the state of three mask registers. The first is a one-bit global mask, which silences every ordinary exception but still lets the non-maskable interrupt and the hard fault through. The second is a one-bit fault mask, which silences hard faults as well, so that only the non-maskable interrupt can get through. The third is a base-priority threshold, which blocks every ordinary exception whose priority value is equal to or greater than the threshold. A threshold of zero turns that check off.

The requester presents a class code and a priority value with a valid strobe. The block returns either a take or a block indication in the same cycle. Software-side logic updates the masks through a small write port that carries a privilege flag, and writes made without privilege are dropped. All three mask values can be read back at all times. Arbitration among several sources and the current execution priority are handled elsewhere.

Top module: `exc_mask_filter`

## Requirements
- R1: After reset the global mask, the fault mask and the threshold all read back as zero, and an ordinary exception of any priority is taken.
- R2: The pend_class code 2'd1 (non-maskable interrupt) is always taken when pend_valid is high, whatever the three masks hold.
- R3: With the global mask set, an ordinary exception (pend_class 2'd0 or 2'd3) is blocked, while a hard fault (pend_class 2'd2) is still taken if the fault mask is clear.
- R4: With the fault mask set, both hard faults and ordinary exceptions are blocked.
- R5: With a non-zero threshold, an ordinary exception is blocked when pend_prio is greater than or equal to the threshold and taken when pend_prio is strictly below it, provided no other mask blocks it.
- R6: A threshold of zero masks nothing, including ordinary exceptions with pend_prio equal to zero.
- R7: The threshold never blocks a hard fault or a non-maskable interrupt.
- R8: A write with wr_priv low leaves all three mask values unchanged.
- R9: A privileged write stores wr_data into the mask that wr_sel selects, and the new value is readable and in effect from the next clock edge. wr_sel 2'd0 selects the global mask (wr_data bit 0), 2'd1 the fault mask (wr_data bit 0), and 2'd2 the threshold (all PRIO_W bits). wr_sel 2'd3 is ignored.
- R10: take and block are both low when pend_valid is low. When pend_valid is high, exactly one of them is high.
- R11: The decision is combinational: it follows changes to pend_class and pend_prio in the same cycle, with no clock edge between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Mask register write strobe |
| wr_priv | input | 1 | Write is made at the privileged level |
| wr_sel | input | 2 | Target mask of the write |
| wr_data | input | PRIO_W | Write value |
| pend_valid | input | 1 | A pending exception is presented |
| pend_class | input | 2 | Class of the pending exception |
| pend_prio | input | PRIO_W | Priority value of the pending exception (lower means more urgent) |
| take | output | 1 | Exception may be taken |
| block | output | 1 | Exception is masked |
| rd_gmask | output | 1 | Global mask readback |
| rd_fmask | output | 1 | Fault mask readback |
| rd_thresh | output | PRIO_W | Threshold readback |

## Verification
Each exception class is presented against each mask set on its own. This separates the global mask, which spares hard faults, from the fault mask, which does not, and shows that the non-maskable interrupt passes every combination. The threshold is swept with priorities one below, equal to and one above its value, and again at zero and at the maximum value. This catches an off-by-one in the compare, a zero threshold that is not treated as disabled, and a threshold that wrongly reaches hard faults. Writes are repeated without privilege and with the unused select code to show that the masks hold, and pending inputs are changed between clock edges to show that the decision does not wait for a register.

// File: rtl/exc_mask_pkg.sv
package exc_mask_pkg;

  localparam int unsigned MAX_PRIO_W = 9;

  typedef enum logic [1:0] {
    CLS_OTHER0 = 2'd0,
    CLS_NMI    = 2'd1,
    CLS_HFAULT = 2'd2,
    CLS_OTHER3 = 2'd3
  } exc_class_e;

  typedef enum logic [1:0] {
    SEL_GLOBAL = 2'd0,
    SEL_FAULT  = 2'd1,
    SEL_THRESH = 2'd2,
    SEL_NONE   = 2'd3
  } mask_sel_e;

  // Threshold compare: zero disables; otherwise a value at or beyond the
  // threshold (numerically) is masked.
  function automatic logic thresh_blocks(input logic [MAX_PRIO_W-1:0] prio,
                                         input logic [MAX_PRIO_W-1:0] thr);
    return (thr != '0) && (prio >= thr);
  endfunction

  function automatic logic is_ordinary(input logic [1:0] cls);
    return (cls == CLS_OTHER0) || (cls == CLS_OTHER3);
  endfunction

endpackage

// File: rtl/exc_mask_regs.sv
module exc_mask_regs
  import exc_mask_pkg::*;
#(
  parameter int unsigned PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_priv,
  input  logic [1:0]        wr_sel,
  input  logic [PRIO_W-1:0] wr_data,
  output logic              gmask,
  output logic              fmask,
  output logic [PRIO_W-1:0] thresh,
  output logic              wr_accept
);

  logic ld_g, ld_f, ld_t;

  assign wr_accept = wr_en && wr_priv && (wr_sel != SEL_NONE);
  assign ld_g      = wr_accept && (wr_sel == SEL_GLOBAL);
  assign ld_f      = wr_accept && (wr_sel == SEL_FAULT);
  assign ld_t      = wr_accept && (wr_sel == SEL_THRESH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gmask  <= 1'b0;
      fmask  <= 1'b0;
      thresh <= '0;
    end else begin
      if (ld_g) gmask  <= wr_data[0];
      if (ld_f) fmask  <= wr_data[0];
      if (ld_t) thresh <= wr_data;
    end
  end

endmodule

// File: rtl/exc_permit_eval.sv
module exc_permit_eval
  import exc_mask_pkg::*;
#(
  parameter int unsigned PRIO_W = 8
) (
  input  logic [1:0]        cls,
  input  logic [PRIO_W-1:0] prio,
  input  logic              gmask,
  input  logic              fmask,
  input  logic [PRIO_W-1:0] thresh,
  output logic              permit_g,
  output logic              permit_f,
  output logic              permit_t
);

  localparam int unsigned PAD_W = MAX_PRIO_W - PRIO_W;

  logic [MAX_PRIO_W-1:0] prio_x, thr_x;

  generate
    if (PAD_W > 0) begin : g_pad
      assign prio_x = {{PAD_W{1'b0}}, prio};
      assign thr_x  = {{PAD_W{1'b0}}, thresh};
    end else begin : g_nopad
      assign prio_x = prio;
      assign thr_x  = thresh;
    end
  endgenerate

  logic ordinary, nmi;
  assign ordinary = is_ordinary(cls);
  assign nmi      = (cls == CLS_NMI);

  assign permit_g = !(gmask && ordinary);
  assign permit_f = !(fmask && !nmi);
  assign permit_t = !(ordinary && thresh_blocks(prio_x, thr_x));

endmodule

// File: rtl/exc_mask_filter.sv
module exc_mask_filter
  import exc_mask_pkg::*;
#(
  parameter int unsigned PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_priv,
  input  logic [1:0]        wr_sel,
  input  logic [PRIO_W-1:0] wr_data,
  input  logic              pend_valid,
  input  logic [1:0]        pend_class,
  input  logic [PRIO_W-1:0] pend_prio,
  output logic              take,
  output logic              block,
  output logic              rd_gmask,
  output logic              rd_fmask,
  output logic [PRIO_W-1:0] rd_thresh
);

  logic              gmask, fmask, wr_accept;
  logic [PRIO_W-1:0] thresh;
  logic              permit_g, permit_f, permit_t, permit_all;

  exc_mask_regs #(.PRIO_W(PRIO_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_priv  (wr_priv),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .gmask    (gmask),
    .fmask    (fmask),
    .thresh   (thresh),
    .wr_accept(wr_accept)
  );

  exc_permit_eval #(.PRIO_W(PRIO_W)) u_eval (
    .cls     (pend_class),
    .prio    (pend_prio),
    .gmask   (gmask),
    .fmask   (fmask),
    .thresh  (thresh),
    .permit_g(permit_g),
    .permit_f(permit_f),
    .permit_t(permit_t)
  );

  assign permit_all = permit_g && permit_f && permit_t;
  assign take       = pend_valid && permit_all;
  assign block      = pend_valid && !permit_all;
  assign rd_gmask   = gmask;
  assign rd_fmask   = fmask;
  assign rd_thresh  = thresh;

endmodule

// File: rtl/exc_mask_filter_sva.sv
module exc_mask_filter_sva
  import exc_mask_pkg::*;
#(
  parameter int unsigned PRIO_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_priv,
  input logic [1:0]        wr_sel,
  input logic [PRIO_W-1:0] wr_data,
  input logic              pend_valid,
  input logic [1:0]        pend_class,
  input logic [PRIO_W-1:0] pend_prio,
  input logic              take,
  input logic              block,
  input logic              rd_gmask,
  input logic              rd_fmask,
  input logic [PRIO_W-1:0] rd_thresh,
  input logic              permit_g,
  input logic              permit_f,
  input logic              permit_t
);

  assert_nmi_passes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && pend_class == CLS_NMI) |-> take);

  assert_gmask_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && rd_gmask && (pend_class == CLS_OTHER0 || pend_class == CLS_OTHER3)) |-> block);

  assert_fmask_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && rd_fmask && pend_class != CLS_NMI) |-> !take);

  assert_thresh_spares_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_class == CLS_HFAULT || pend_class == CLS_NMI) |-> permit_t);

  assert_zero_thresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_thresh == '0) |-> permit_t);

  assert_unpriv_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_priv) |=> ($stable(rd_gmask) && $stable(rd_fmask) && $stable(rd_thresh)));

  assert_thresh_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_priv && wr_sel == SEL_THRESH) |=> (rd_thresh == $past(wr_data)));

  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid ? $onehot({take, block}) : ({take, block} == 2'b00));

endmodule

bind exc_mask_filter exc_mask_filter_sva #(.PRIO_W(PRIO_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_priv   (wr_priv),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .pend_valid(pend_valid),
  .pend_class(pend_class),
  .pend_prio (pend_prio),
  .take      (take),
  .block     (block),
  .rd_gmask  (rd_gmask),
  .rd_fmask  (rd_fmask),
  .rd_thresh (rd_thresh),
  .permit_g  (permit_g),
  .permit_f  (permit_f),
  .permit_t  (permit_t)
);

// File: tb/exc_mask_filter_tb_top.sv
module exc_mask_filter_tb_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0, wr_priv = 1'b0;
  logic [1:0]   wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic         pend_valid = 1'b0;
  logic [1:0]   pend_class = 2'd0;
  logic [W-1:0] pend_prio = '0;
  logic         take, block, rd_gmask, rd_fmask;
  logic [W-1:0] rd_thresh;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  exc_mask_filter #(.PRIO_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_priv(wr_priv),
    .wr_sel(wr_sel), .wr_data(wr_data), .pend_valid(pend_valid),
    .pend_class(pend_class), .pend_prio(pend_prio), .take(take),
    .block(block), .rd_gmask(rd_gmask), .rd_fmask(rd_fmask),
    .rd_thresh(rd_thresh)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Bench model of the decision, written from the requirement list.
  function automatic bit model_take(input bit g, input bit f, input int thr,
                                    input int cls, input int prio);
    if (cls == 1) return 1;
    if (f) return 0;
    if (cls == 2) return 1;
    if (g) return 0;
    if (thr != 0 && prio >= thr) return 0;
    return 1;
  endfunction

  task automatic write_reg(input int sel, input int val, input bit priv);
    @(negedge clk);
    wr_en = 1; wr_priv = priv; wr_sel = sel[1:0]; wr_data = val[W-1:0];
    @(negedge clk);
    wr_en = 0; wr_priv = 0;
  endtask

  task automatic probe(input string req, input int cls, input int prio, input bit exp_take);
    pend_valid = 1; pend_class = cls[1:0]; pend_prio = prio[W-1:0];
    #1;
    chk(req, take, exp_take);
    chk(req, block, !exp_take);
  endtask

  task automatic t_reset();
    chk("R1 gmask", rd_gmask, 0);
    chk("R1 fmask", rd_fmask, 0);
    chk("R1 thresh", rd_thresh, 0);
    @(negedge clk);
    probe("R1 other taken", 0, 200, 1);
    probe("R1 other3 taken", 3, 0, 1);
  endtask

  task automatic t_idle();
    @(negedge clk);
    pend_valid = 0; pend_class = 1; #1;
    chk("R10 idle take", take, 0);
    chk("R10 idle block", block, 0);
  endtask

  task automatic t_global();
    write_reg(0, 1, 1);
    chk("R9 gmask write", rd_gmask, 1);
    probe("R3 other blocked", 0, 5, 0);
    probe("R3 hfault taken", 2, 5, 1);
    probe("R2 nmi under gmask", 1, 5, 1);
    write_reg(0, 0, 1);
    chk("R9 gmask clear", rd_gmask, 0);
  endtask

  task automatic t_fault();
    write_reg(1, 1, 1);
    chk("R9 fmask write", rd_fmask, 1);
    probe("R4 hfault blocked", 2, 0, 0);
    probe("R4 other blocked", 3, 0, 0);
    probe("R2 nmi under fmask", 1, 0, 1);
    write_reg(1, 0, 1);
  endtask

  task automatic t_thresh();
    write_reg(2, 16, 1);
    chk("R9 thresh write", rd_thresh, 16);
    probe("R5 below", 0, 15, 1);
    probe("R5 equal", 0, 16, 0);
    probe("R5 above", 3, 17, 0);
    probe("R7 hfault above", 2, 200, 1);
    probe("R2 nmi above", 1, 255, 1);
    write_reg(2, 1, 1);
    probe("R5 thr1 prio0", 0, 0, 1);
    probe("R5 thr1 prio1", 0, 1, 0);
    write_reg(2, 255, 1);
    probe("R5 thrmax 254", 0, 254, 1);
    probe("R5 thrmax 255", 0, 255, 0);
    write_reg(2, 0, 1);
    probe("R6 zero thr prio0", 0, 0, 1);
    probe("R6 zero thr prio255", 0, 255, 1);
  endtask

  task automatic t_unpriv();
    write_reg(2, 40, 1);
    write_reg(0, 1, 0);
    write_reg(1, 1, 0);
    write_reg(2, 3, 0);
    chk("R8 gmask held", rd_gmask, 0);
    chk("R8 fmask held", rd_fmask, 0);
    chk("R8 thresh held", rd_thresh, 40);
    probe("R8 decision unchanged", 0, 39, 1);
    write_reg(3, 1, 1);
    chk("R9 sel3 gmask", rd_gmask, 0);
    chk("R9 sel3 fmask", rd_fmask, 0);
    chk("R9 sel3 thresh", rd_thresh, 40);
  endtask

  task automatic t_comb();
    @(negedge clk);
    probe("R11 first", 0, 10, 1);
    #2;
    probe("R11 change same cycle", 0, 50, 0);
    #1;
    probe("R11 back same cycle", 2, 50, 1);
  endtask

  task automatic t_sweep();
    for (int m = 0; m < 4; m++) begin
      write_reg(0, m & 1, 1);
      write_reg(1, (m >> 1) & 1, 1);
      for (int c = 0; c < 4; c++) begin
        for (int p = 38; p < 42; p++) begin
          probe("R2 R3 R4 R5 sweep", c, p,
                model_take(m[0], m[1], 40, c, p));
        end
      end
    end
    write_reg(0, 0, 1);
    write_reg(1, 0, 1);
  endtask

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_idle();
    t_global();
    t_fault();
    t_thresh();
    t_unpriv();
    t_comb();
    t_sweep();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule